// File: doc/BRIEF.md
# Port Disconnect Timer

This block watches one powered port for the removal of its load. A current comparator outside the block reports when the port current has dropped below the minimum hold level. While the port is on, detection is enabled and that indication stays asserted, the block counts slow ticks. When the count reaches a programmable limit, the block requests that the port be switched off and latches a disconnect fault bit. The fault bit holds until the host clears it. If the load draws current again before the limit is reached, the count starts over. A load that draws current in bursts spaced closer together than the timeout therefore stays powered.

Two enable inputs arm the detection. One requests DC disconnect. The other is a legacy AC-disconnect enable, which is served by the same DC mechanism. With both enables clear, an unloaded port stays powered indefinitely. One instance is placed per port.

Top module: `port_disconnect_timer`

## Requirements
- R1: After reset, portOff and disFault are 0 and the qualified-tick count is zero.
- R2: A qualified tick is a cycle with tick=1, portOn=1, lowCurrent=1 and at least one enable set. Each qualified tick adds one to the count. On the qualified tick that brings the count to timeLimit, portOff is 1 for exactly the following cycle, disFault becomes 1 in that same cycle, and the count returns to zero.
- R3: Any cycle with lowCurrent=0 returns the count to zero, so the next expiry needs a full timeLimit qualified ticks.
- R4: If no run of consecutive low-current qualified ticks reaches timeLimit, portOff never asserts.
- R5: With dcEnable=0 and acEnable=0, the count is held at zero, portOff stays 0 and disFault keeps its value.
- R6: With acEnable=1 and dcEnable=0, expiry timing is the same as with dcEnable=1.
- R7: While portOn=0, the count is held at zero and portOff stays 0.
- R8: disFault stays 1 until a cycle with faultClear=1 clears it. When an expiry and faultClear fall in the same cycle, the fault stays set.
- R9: The limit is compared live. A timeLimit of 0 or 1 expires on the first qualified tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timebase pulse |
| lowCurrent | input | 1 | Port current is below the hold level |
| portOn | input | 1 | Port power is on |
| dcEnable | input | 1 | DC disconnect enable |
| acEnable | input | 1 | Legacy AC disconnect enable, served by the DC mechanism |
| timeLimit | input | CNT_W | Timeout in qualified ticks |
| faultClear | input | 1 | Host clear of the fault bit |
| portOff | output | 1 | One-cycle request to turn the port off |
| disFault | output | 1 | Latched disconnect fault |

## Verification
The bench targets current that returns one tick short of the limit. A design that does not reset on recovery, or that counts off by one, would cut power to a live load there. It also covers limits of 0 and 1, where a design with an unguarded compare would wrap around and never expire. Other cases are expiry while faultClear is asserted, where clear-wins logic would lose the fault, and a port with only the legacy enable set, where a design ignoring that enable would leave the port on. Random runs add ticks while the port is off or disabled, which a design that keeps its count across those cycles would turn into an early expiry.

// File: rtl/port_disconnect_pkg.sv
package port_disconnect_pkg;
  typedef struct packed {
    logic clr;
    logic inc;
  } cntStrobe_t;
endpackage

// File: rtl/disconnect_datapath.sv
module disconnect_datapath
  import port_disconnect_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [CNT_W-1:0] timeLimit,
  output logic             lastStep
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [EXT_W-1:0] cntNext;

  assign cntNext  = {1'b0, cnt} + EXT_W'(1);
  assign lastStep = cntNext >= {1'b0, timeLimit};

  always_ff @(posedge clk) begin
    if (!rstN)           cnt <= '0;
    else if (strobe.clr) cnt <= '0;
    else if (strobe.inc) cnt <= cntNext[CNT_W-1:0];
  end

  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> (cnt == '0));
  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inc && !strobe.clr) |=> (cnt == $past(cnt) + CNT_W'(1)));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.inc && !strobe.clr) |=> $stable(cnt));
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.inc |-> !lastStep);
endmodule

// File: rtl/disconnect_control.sv
module disconnect_control
  import port_disconnect_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       lowCurrent,
  input  logic       portOn,
  input  logic       dcEnable,
  input  logic       acEnable,
  input  logic       faultClear,
  input  logic       lastStep,
  output cntStrobe_t strobe,
  output logic       portOff,
  output logic       disFault
);
  logic detectOn;
  logic armed;
  logic expire;

  // the legacy AC enable maps onto the DC mechanism
  assign detectOn = dcEnable | acEnable;
  assign armed    = detectOn & portOn & lowCurrent;
  assign expire   = armed & tick & lastStep;

  always_comb begin
    strobe.clr = !armed || expire;
    strobe.inc = armed && tick && !lastStep;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portOff  <= 1'b0;
      disFault <= 1'b0;
    end else begin
      portOff  <= expire;
      disFault <= expire | (disFault & ~faultClear);
    end
  end

  p_off_sets_fault_r2: assert property (@(posedge clk) disable iff (!rstN)
    portOff |-> disFault);
  p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!dcEnable && !acEnable) |=> !portOff);
  p_port_off_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !portOn |=> !portOff);
  p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (disFault && !faultClear) |=> disFault);
  p_no_tick_no_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> !portOff);
endmodule

// File: rtl/port_disconnect_timer.sv
module port_disconnect_timer
  import port_disconnect_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             lowCurrent,
  input  logic             portOn,
  input  logic             dcEnable,
  input  logic             acEnable,
  input  logic [CNT_W-1:0] timeLimit,
  input  logic             faultClear,
  output logic             portOff,
  output logic             disFault
);
  cntStrobe_t strobe;
  logic       lastStep;

  disconnect_control u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .lowCurrent(lowCurrent),
    .portOn(portOn), .dcEnable(dcEnable), .acEnable(acEnable),
    .faultClear(faultClear), .lastStep(lastStep), .strobe(strobe),
    .portOff(portOff), .disFault(disFault)
  );

  disconnect_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .timeLimit(timeLimit),
    .lastStep(lastStep)
  );
endmodule

// File: tb/tb_port_disconnect_timer.sv
module tb_port_disconnect_timer;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN, tick, lowCurrent, portOn, dcEnable, acEnable, faultClear;
  logic [CNT_W-1:0] timeLimit;
  logic portOff, disFault;

  int nTests = 0;
  int nFail  = 0;
  int mCnt   = 0;
  bit mOff   = 0;
  bit mFault = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  port_disconnect_timer #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .tick(tick), .lowCurrent(lowCurrent),
    .portOn(portOn), .dcEnable(dcEnable), .acEnable(acEnable),
    .timeLimit(timeLimit), .faultClear(faultClear),
    .portOff(portOff), .disFault(disFault)
  );

  function automatic int effLimit(input int lim);
    return (lim < 1) ? 1 : lim;
  endfunction

  function automatic bit isQualified();
    return tick && portOn && lowCurrent && (dcEnable || acEnable);
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // advance one clock, update the model, compare
  task automatic cycle(input string tag);
    bit expire;
    bit armed;
    armed  = portOn && lowCurrent && (dcEnable || acEnable);
    expire = isQualified() && (mCnt + 1 >= effLimit(int'(timeLimit)));
    @(posedge clk);
    @(negedge clk);
    if (!armed || expire) mCnt = 0;
    else if (tick) mCnt = mCnt + 1;
    mOff   = expire;
    mFault = expire || (mFault && !faultClear);
    check(tag, "portOff", int'(portOff), int'(mOff));
    check(tag, "disFault", int'(disFault), int'(mFault));
  endtask

  task automatic setIn(input bit t, input bit lc, input bit on, input bit dc,
                       input bit ac, input bit fc);
    tick = t; lowCurrent = lc; portOn = on; dcEnable = dc; acEnable = ac; faultClear = fc;
  endtask

  // run n ticks with low current; returns number of portOff pulses seen
  task automatic lowTicks(input string tag, input int n, input bit dc, input bit ac,
                          output int offs);
    offs = 0;
    for (int i = 0; i < n; i++) begin
      setIn(1, 1, 1, dc, ac, 0);
      cycle(tag);
      offs += int'(portOff);
      setIn(0, 1, 1, dc, ac, 0);
      cycle(tag);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin : stim
    int offs;
    void'($urandom(32'd1234));
    rstN = 1'b0; timeLimit = CNT_W'(4);
    setIn(0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "portOff", int'(portOff), 0);
    check("R1", "disFault", int'(disFault), 0);
    rstN = 1'b1;

    // R2: exact expiry on the 4th qualified tick
    lowTicks("R2", 3, 1, 0, offs);
    check("R2", "no off before limit", offs, 0);
    lowTicks("R2", 1, 1, 0, offs);
    check("R2", "off at limit", offs, 1);
    setIn(0, 0, 1, 1, 0, 1); cycle("R8");

    // R3/R4: recover one tick short, repeatedly
    for (int k = 0; k < 5; k++) begin
      lowTicks("R4", 3, 1, 0, offs);
      check("R4", "short run no off", offs, 0);
      setIn(0, 0, 1, 1, 0, 0); cycle("R3");
    end
    lowTicks("R3", 3, 1, 0, offs);
    check("R3", "full count after recovery", offs, 0);
    lowTicks("R3", 1, 1, 0, offs);
    check("R3", "expiry after full count", offs, 1);

    // R5: disabled, long unloaded stretch
    lowTicks("R5", 20, 0, 0, offs);
    check("R5", "disabled no off", offs, 0);
    check("R5", "fault kept", int'(disFault), 1);

    // R8: clear, then expiry with clear in the same cycle
    setIn(0, 0, 1, 1, 0, 1); cycle("R8");
    check("R8", "cleared", int'(disFault), 0);
    lowTicks("R8", 3, 1, 0, offs);
    setIn(1, 1, 1, 1, 0, 1); cycle("R8");
    check("R8", "set beats clear", int'(disFault), 1);
    setIn(0, 0, 1, 1, 0, 1); cycle("R8");

    // R6: legacy enable alone
    lowTicks("R6", 3, 0, 1, offs);
    check("R6", "ac no early off", offs, 0);
    lowTicks("R6", 1, 0, 1, offs);
    check("R6", "ac expiry", offs, 1);

    // R7: port off holds count at zero
    lowTicks("R7", 2, 1, 0, offs);
    setIn(1, 1, 0, 1, 0, 0); cycle("R7"); cycle("R7"); cycle("R7");
    check("R7", "no off while port off", int'(portOff), 0);
    lowTicks("R7", 3, 1, 0, offs);
    check("R7", "count restarted", offs, 0);

    // R9: limits 0 and 1
    timeLimit = '0;
    setIn(0, 0, 1, 1, 0, 0); cycle("R9");
    lowTicks("R9", 1, 1, 0, offs);
    check("R9", "limit 0 first tick", offs, 1);
    timeLimit = CNT_W'(1);
    lowTicks("R9", 1, 1, 0, offs);
    check("R9", "limit 1 first tick", offs, 1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 99) == 0) timeLimit = CNT_W'($urandom_range(0, 6));
      setIn($urandom_range(0, 2) == 0, $urandom_range(0, 9) != 0,
            $urandom_range(0, 9) != 0, $urandom_range(0, 3) != 0,
            $urandom_range(0, 3) == 0, $urandom_range(0, 19) == 0);
      cycle("R2");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule